// File: doc/BRIEF.md
# Compare/Capture Real-Time Counter

This block is a 51-bit free-running counter that advances once per cycle in which its tick enable is high. Software sees the count through two 32-bit windows that overlap: a fine window taken from count bits [34:3] and a coarse window taken from count bits [50:19]. When the count passes its maximum value it wraps back to zero. A restart write returns the count to zero, and counting carries on from there.

Two single-shot channels run alongside the counter. The compare channel is armed by writing a threshold. While armed, it fires once when the fine window becomes equal to the threshold or greater than it. The capture channel is armed by an explicit write. While armed, it samples the low 21 bits of the fine window on the chosen edge of a capture input, and that input is first passed through a synchronizer. Each channel disarms itself when it fires. A debug mode bit lets a core-halted input freeze the counter and both channels.

All writes share one data bus and use one strobe per function. Register decoding and interrupt status live outside this block.

Top module: `rtc_cc_timer`

## Requirements
- R1: While tick is high and the block is not frozen, the count rises by one on each clock edge. With tick low it holds. time_lo shows count bits [34:3] and time_hi shows count bits [50:19].
- R2: A restart strobe with wdata[0]=1 makes the count zero after the next edge. A restart strobe with wdata[0]=0 leaves the count unchanged.
- R3: A compare strobe loads wdata as the threshold and sets armed[0] after the next edge.
- R4: If armed[0] is 1, the block is not frozen and time_lo >= threshold in some cycle, then ev_cmp is high for exactly the following cycle and armed[0] falls. This includes a threshold that has already been passed when it is written.
- R5: An arm-set strobe with wdata[1]=1 sets armed[1]. wdata[0] of an arm-set strobe has no effect on either channel.
- R6: cap_in passes through two synchronizing flops before edge detection. The edge select is 0 for rising and 1 for falling. With armed[1] at 1, a selected edge loads cap_val with time_lo[20:0], pulses ev_cap for one cycle and clears armed[1]. A cap_in change driven before edge k produces that pulse after edge k+2.
- R7: While armed[1] is 0, edges on cap_in leave cap_val unchanged and do not raise ev_cap.
- R8: An arm-clear strobe clears armed[0] for wdata[0]=1 and armed[1] for wdata[1]=1, and raises no event. If the cleared channel fires in that same cycle, its event still occurs. If an arm and a clear for the same channel land in the same cycle, the clear wins.
- R9: When the halt-mode bit (wdata[0] of its strobe) is 1 and core_halted is high, the count holds and neither channel fires. Normal operation resumes once core_halted falls. When the halt-mode bit is 0, core_halted has no effect.
- R10: While reset is asserted, the count, threshold, cap_val, the armed flags, the events, the edge select and the halt-mode bit are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable |
| wdata | input | 32 | Write data shared by all strobes |
| we_restart | input | 1 | Restart strobe, acts when wdata[0] is 1 |
| we_cmp | input | 1 | Threshold write; also arms the compare channel |
| we_arm_set | input | 1 | Arm strobe, wdata[1] arms the capture channel |
| we_arm_clr | input | 1 | Disarm strobe, wdata[1:0] selects the channels |
| we_edge | input | 1 | Edge select write, wdata[0]: 0 rising, 1 falling |
| we_halt_mode | input | 1 | Halt-mode write, wdata[0]: 1 freezes on halt |
| core_halted | input | 1 | Debug halt indication |
| cap_in | input | 1 | Asynchronous capture source |
| time_lo | output | 32 | Count bits [34:3] |
| time_hi | output | 32 | Count bits [50:19] |
| cap_val | output | 21 | Last captured time_lo[20:0] |
| ev_cmp | output | 1 | Compare event pulse |
| ev_cap | output | 1 | Capture event pulse |
| armed | output | 2 | Armed flags: bit 0 compare, bit 1 capture |

## Verification
The timing-sensitive cases come from a disarm write landing in the same cycle as that channel firing. The bench provokes this in two ways. It writes a threshold of zero and places the arm-clear strobe in the very next cycle, which is when the match is first seen. It also places the clear in the cycle where a synchronized capture edge is detected. In both cases the verdict is that the event pulse still appears and the armed flag ends low. A third collision drives a compare write and an arm-clear strobe in the same cycle, and here the armed flag must stay low with no event.

// File: rtl/rtc_cc_timer.sv
module rtc_cc_timer #(
  parameter int CNT_W  = 51,
  parameter int WIN_W  = 32,
  parameter int LO_LSB = 3,
  parameter int HI_LSB = 19,
  parameter int CAP_W  = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIN_W-1:0] wdata,
  input  logic             we_restart,
  input  logic             we_cmp,
  input  logic             we_arm_set,
  input  logic             we_arm_clr,
  input  logic             we_edge,
  input  logic             we_halt_mode,
  input  logic             core_halted,
  input  logic             cap_in,
  output logic [WIN_W-1:0] time_lo,
  output logic [WIN_W-1:0] time_hi,
  output logic [CAP_W-1:0] cap_val,
  output logic             ev_cmp,
  output logic             ev_cap,
  output logic [1:0]       armed
);

  logic [CNT_W-1:0] cnt_q;
  logic [WIN_W-1:0] cmp_q;
  logic             arm0_q, arm1_q, fall_q, halt_en_q;
  logic [2:0]       sync_q;

  wire frozen   = halt_en_q & core_halted;
  wire restart  = we_restart & wdata[0];
  wire edge_hit = fall_q ? (~sync_q[1] & sync_q[2]) : (sync_q[1] & ~sync_q[2]);
  wire fire0    = arm0_q & ~frozen & (time_lo >= cmp_q);
  wire fire1    = arm1_q & ~frozen & edge_hit;
  wire clr0     = we_arm_clr & wdata[0];
  wire clr1     = we_arm_clr & wdata[1];
  wire set1     = we_arm_set & wdata[1];

  assign time_lo = cnt_q[LO_LSB +: WIN_W];
  assign time_hi = cnt_q[HI_LSB +: WIN_W];
  assign armed   = {arm1_q, arm0_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cmp_q     <= '0;
      arm0_q    <= 1'b0;
      arm1_q    <= 1'b0;
      fall_q    <= 1'b0;
      halt_en_q <= 1'b0;
      sync_q    <= '0;
      cap_val   <= '0;
      ev_cmp    <= 1'b0;
      ev_cap    <= 1'b0;
    end else begin
      if (restart)               cnt_q <= '0;
      else if (tick && !frozen)  cnt_q <= cnt_q + 1'b1;
      if (we_cmp)       cmp_q     <= wdata;
      if (we_edge)      fall_q    <= wdata[0];
      if (we_halt_mode) halt_en_q <= wdata[0];
      sync_q <= {sync_q[1], sync_q[0], cap_in};
      arm0_q <= (we_cmp | (arm0_q & ~fire0)) & ~clr0;
      arm1_q <= (set1 | (arm1_q & ~fire1)) & ~clr1;
      ev_cmp <= fire0;
      ev_cap <= fire1;
      if (fire1) cap_val <= time_lo[CAP_W-1:0];
    end
  end

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !frozen && !restart) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R2
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);

  // R4
  cmp_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |-> $past(arm0_q));

  // R6
  cap_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap |-> $past(arm1_q));

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cap |-> $stable(cap_val));

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !restart) |=> (cnt_q == $past(cnt_q)) && !ev_cmp && !ev_cap);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr0 |=> !arm0_q);

endmodule

// File: tb/sim_rtc_cc_timer.sv
`timescale 1ns/1ps
module sim_rtc_cc_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [31:0] wdata = '0;
  logic we_restart = 0, we_cmp = 0, we_arm_set = 0, we_arm_clr = 0, we_edge = 0, we_halt_mode = 0;
  logic core_halted = 0, cap_in = 0;
  logic [31:0] time_lo, time_hi;
  logic [20:0] cap_val;
  logic ev_cmp, ev_cap;
  logic [1:0] armed;

  always #2 clk = ~clk;

  rtc_cc_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wdata(wdata),
    .we_restart(we_restart), .we_cmp(we_cmp), .we_arm_set(we_arm_set),
    .we_arm_clr(we_arm_clr), .we_edge(we_edge), .we_halt_mode(we_halt_mode),
    .core_halted(core_halted), .cap_in(cap_in), .time_lo(time_lo), .time_hi(time_hi),
    .cap_val(cap_val), .ev_cmp(ev_cmp), .ev_cap(ev_cap), .armed(armed));

  // behavioural reference
  longint unsigned m_cnt = 0;
  bit [31:0] m_cmp = 0;
  bit m_arm0 = 0, m_arm1 = 0, m_fall = 0, m_halt = 0, m_ev0 = 0, m_ev1 = 0;
  bit [20:0] m_cap = 0;
  bit sq[$] = '{0, 0, 0};
  longint unsigned cnt_mask = (64'd1 << 51) - 1;

  function automatic bit [31:0] lo_of(longint unsigned c);
    return 32'(c >> 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_arm0 = 0; m_arm1 = 0; m_fall = 0; m_halt = 0;
      m_ev0 = 0; m_ev1 = 0; m_cap = 0; sq = '{0, 0, 0};
    end else begin
      automatic bit frz = m_halt && core_halted;
      automatic bit [31:0] lo = lo_of(m_cnt);
      automatic bit hit = m_fall ? (!sq[1] && sq[2]) : (sq[1] && !sq[2]);
      automatic bit f0 = m_arm0 && !frz && (lo >= m_cmp);
      automatic bit f1 = m_arm1 && !frz && hit;
      m_ev0 = f0;
      m_ev1 = f1;
      if (f1) m_cap = lo[20:0];
      m_arm0 = (we_cmp || (m_arm0 && !f0)) && !(we_arm_clr && wdata[0]);
      m_arm1 = ((we_arm_set && wdata[1]) || (m_arm1 && !f1)) && !(we_arm_clr && wdata[1]);
      if (we_cmp) m_cmp = wdata;
      if (we_edge) m_fall = wdata[0];
      if (we_halt_mode) m_halt = wdata[0];
      if (we_restart && wdata[0]) m_cnt = 0;
      else if (tick && !frz) m_cnt = (m_cnt + 1) & cnt_mask;
      sq.push_front(cap_in);
      void'(sq.pop_back());
    end
  end

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R10";

  task automatic chk(string fld, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, fld, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("time_lo R1", 64'(time_lo), 64'(lo_of(m_cnt)));
    chk("time_hi R1", 64'(time_hi), 64'(32'(m_cnt >> 19)));
    chk("cap_val", 64'(cap_val), 64'(m_cap));
    chk("ev_cmp", 64'(ev_cmp), 64'(m_ev0));
    chk("ev_cap", 64'(ev_cap), 64'(m_ev1));
    chk("armed", 64'(armed), 64'({m_arm1, m_arm0}));
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      finish_run();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // sel: 0 restart, 1 cmp, 2 arm set, 3 arm clear, 4 edge, 5 halt mode
  task automatic wr(int sel, logic [31:0] d);
    wdata = d;
    case (sel)
      0: we_restart = 1;
      1: we_cmp = 1;
      2: we_arm_set = 1;
      3: we_arm_clr = 1;
      4: we_edge = 1;
      default: we_halt_mode = 1;
    endcase
    @(negedge clk);
    {we_restart, we_cmp, we_arm_set, we_arm_clr, we_edge, we_halt_mode} = '0;
    wdata = '0;
  endtask

  initial begin
    cur_req = "R10"; idle(3); rst_n = 1; idle(2);
    cur_req = "R1"; tick = 1; idle(60); tick = 0; idle(10); tick = 1; idle(20);
    cur_req = "R2"; wr(0, 32'h0); idle(5); wr(0, 32'h1); idle(30);
    cur_req = "R3"; wr(1, lo_of(m_cnt) + 6); idle(3);
    cur_req = "R4"; idle(70); wr(1, 32'h1); idle(5);
    cur_req = "R5"; wr(2, 32'h1); idle(5); wr(2, 32'h2); idle(3);
    cur_req = "R6"; cap_in = 1; idle(6); cap_in = 0; idle(6);
    wr(4, 32'h1); wr(2, 32'h2); idle(20); cap_in = 1; idle(6); cap_in = 0; idle(6);
    cur_req = "R7"; cap_in = 1; idle(6); cap_in = 0; idle(6); cap_in = 1; idle(6);
    cur_req = "R8"; wr(1, 32'hFFFF_0000); idle(4); wr(3, 32'h1); idle(4);
    wr(1, 32'h0); wr(3, 32'h1); idle(4);
    wr(4, 32'h0); cap_in = 0; idle(5); wr(2, 32'h2); cap_in = 1; idle(2); wr(3, 32'h2); idle(6);
    wdata = 32'h0; we_cmp = 1; we_arm_clr = 1; wdata = 32'h1; @(negedge clk);
    we_cmp = 0; we_arm_clr = 0; wdata = 0; idle(4);
    cur_req = "R9"; core_halted = 1; idle(10); wr(5, 32'h1); idle(10);
    wr(1, 32'h0); wr(2, 32'h2); cap_in = 0; idle(8); core_halted = 0; idle(10);
    core_halted = 1; idle(5); wr(5, 32'h0); idle(10); core_halted = 0; idle(10);
    finish_run();
  end
endmodule